// File: doc/BRIEF.md
# Banked Shared Scratchpad

This block is a software-managed on-chip scratchpad shared by every lane of one vector issue. Storage is split into 32 independent banks, each one 32-bit word wide, and each bank can serve one word per cycle. When no two lanes collide in a bank, a 16-lane request finishes in a single service cycle.

A request carries an operation for the whole issue (read, write or atomic add), a mask of active lanes, one word address per lane and, for writes and atomics, one data word per lane. The block accepts the request with a valid/ready handshake. It then services the lanes over as many cycles as bank conflicts demand. Each cycle, every bank picks its lowest-numbered pending lane and serves that lane together with every pending lane that addresses the same word. Atomic adds run inside the scratchpad and return the value held before the add. Atomic lanes are never grouped, so lanes that collide on one word are applied one after another. When every active lane has been served, a one-cycle completion pulse is raised and the gathered read data is presented.

Top module: `sp_scratchpad`

## Requirements
- R1: After reset, `req_ready_o` is 1, `done_o` is 0 and every lane of `rdata_o` is 0.
- R2: A lane's word address selects bank = address bits [4:0], which are byte-address bits [6:2]. The row is given by the bits above those. Two addresses that differ only in the row land in the same bank.
- R3: If all active lanes of a request use different banks, `done_o` is 1 in the cycle after the first rising edge that follows the accepting edge.
- R4: For reads and writes, the number of service cycles equals the largest count of distinct words addressed by active lanes within any one bank. For atomic adds, it equals the largest count of active lanes within any one bank. The minimum is one cycle, which also applies when the mask is empty.
- R5: Active read lanes that address the same word are served together in one cycle, and each of them receives that word.
- R6: Operation encoding: 2'b00 read, 2'b01 write, 2'b10 atomic add. An atomic add stores old+data and returns old to its lane. Lanes that hit the same word are applied in ascending lane order, each lane seeing the sum left by the lanes below it.
- R7: When several active write lanes in one request target the same word, the data of the highest-numbered of those lanes is stored.
- R8: A word written or atomically updated by a completed request is returned by any later read.
- R9: `req_ready_o` is 0 from the cycle after acceptance until `done_o`. A request presented while busy is ignored and leaves the storage unchanged.
- R10: Inactive lanes return 0 in `rdata_o` and do not modify the storage. Write requests return 0 on all lanes.
- R11: `done_o` is a single-cycle pulse raised only while the block is idle. `rdata_o` holds its value from the pulse until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_op_i | input | 2 | Operation: read, write or atomic add |
| req_mask_i | input | NUM_LANES | Active-lane mask |
| req_addr_i | input | NUM_LANES*ADDR_W | Per-lane word address |
| req_wdata_i | input | NUM_LANES*DATA_W | Per-lane write or addend data |
| done_o | output | 1 | Completion pulse |
| rdata_o | output | NUM_LANES*DATA_W | Per-lane gathered result |

## Verification
Two functions can fall in the same cycle: the broadcast grouping of one bank, and the separate service of other banks holding different conflict depths. A single atomic add can also update a word while the lanes below it are still being counted. These cases are provoked with mixed patterns, such as half the lanes sharing one word and the rest spread across rows of the same bank, and with 16 atomic adds to a single word. A reference model in the bench processes lanes in ascending order over a flat word array. For every request, it predicts both the cycle in which the completion pulse appears and each lane's returned value, and it checks the handshake at every clock while the request is in flight.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    OP_READ    = 2'b00,
    OP_WRITE   = 2'b01,
    OP_AMO_ADD = 2'b10
  } sp_op_e;
endpackage

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 5,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[row_i] <= wdata_i;
  end

  assign rdata_o = mem_q[row_i];
endmodule

// File: rtl/sp_bank_arb.sv
module sp_bank_arb #(
  parameter int NUM_LANES = 16,
  parameter int BANK_W    = 5,
  parameter int ROW_W     = 5,
  parameter int DATA_W    = 32,
  parameter int BANK_ID   = 0
) (
  input  logic [NUM_LANES-1:0]             pend_i,
  input  logic [NUM_LANES-1:0][BANK_W-1:0] lane_bank_i,
  input  logic [NUM_LANES-1:0][ROW_W-1:0]  lane_row_i,
  input  logic [NUM_LANES-1:0][DATA_W-1:0] lane_wdata_i,
  input  logic                             single_i,
  output logic [NUM_LANES-1:0]             grant_o,
  output logic                             any_o,
  output logic [ROW_W-1:0]                 row_o,
  output logic [DATA_W-1:0]                wdata_o
);
  logic [NUM_LANES-1:0] cand;
  int unsigned          lead;

  always_comb begin
    any_o = 1'b0;
    lead  = 0;
    for (int l = 0; l < NUM_LANES; l++) begin
      cand[l] = pend_i[l] && (lane_bank_i[l] == BANK_W'(BANK_ID));
      if (cand[l] && !any_o) begin
        any_o = 1'b1;
        lead  = l;
      end
    end
    row_o   = lane_row_i[lead];
    wdata_o = lane_wdata_i[lead];
    for (int l = 0; l < NUM_LANES; l++) begin
      // broadcast group: same word as lead; atomics take the lead lane only
      grant_o[l] = cand[l] && (lane_row_i[l] == row_o) && (!single_i || l == lead);
      if (grant_o[l]) wdata_o = lane_wdata_i[l];  // highest granted lane wins
    end
  end
endmodule

// File: rtl/sp_scratchpad.sv
module sp_scratchpad
  import sp_pkg::*;
#(
  parameter int NUM_LANES = 16,
  parameter int NUM_BANKS = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = ADDR_W - BANK_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_valid_i,
  output logic                             req_ready_o,
  input  logic [1:0]                       req_op_i,
  input  logic [NUM_LANES-1:0]             req_mask_i,
  input  logic [NUM_LANES-1:0][ADDR_W-1:0] req_addr_i,
  input  logic [NUM_LANES-1:0][DATA_W-1:0] req_wdata_i,
  output logic                             done_o,
  output logic [NUM_LANES-1:0][DATA_W-1:0] rdata_o
);
  logic                             busy_q, done_q;
  logic [1:0]                       op_q;
  logic [NUM_LANES-1:0]             pend_q;
  logic [NUM_LANES-1:0][BANK_W-1:0] bank_q;
  logic [NUM_LANES-1:0][ROW_W-1:0]  row_q;
  logic [NUM_LANES-1:0][DATA_W-1:0] wdata_q, rdata_q;

  logic is_wr, is_amo;
  logic [NUM_BANKS-1:0][NUM_LANES-1:0] grant;
  logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_rd;
  logic [NUM_LANES-1:0]                served, pend_nxt;
  logic [NUM_LANES-1:0][DATA_W-1:0]    lane_rd;

  assign is_wr  = (op_q == OP_WRITE);
  assign is_amo = (op_q == OP_AMO_ADD);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              any;
    logic [ROW_W-1:0]  row;
    logic [DATA_W-1:0] arb_wd, bank_wd;

    sp_bank_arb #(
      .NUM_LANES(NUM_LANES), .BANK_W(BANK_W), .ROW_W(ROW_W),
      .DATA_W(DATA_W), .BANK_ID(b)
    ) u_arb (
      .pend_i      (busy_q ? pend_q : '0),
      .lane_bank_i (bank_q),
      .lane_row_i  (row_q),
      .lane_wdata_i(wdata_q),
      .single_i    (is_amo),
      .grant_o     (grant[b]),
      .any_o       (any),
      .row_o       (row),
      .wdata_o     (arb_wd)
    );

    assign bank_wd = is_amo ? bank_rd[b] + arb_wd : arb_wd;

    sp_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_bank (
      .clk_i  (clk_i),
      .we_i   (any && (is_wr || is_amo)),
      .row_i  (row),
      .wdata_i(bank_wd),
      .rdata_o(bank_rd[b])
    );
  end

  always_comb begin
    served = '0;
    for (int b = 0; b < NUM_BANKS; b++) served |= grant[b];
    for (int l = 0; l < NUM_LANES; l++) lane_rd[l] = bank_rd[bank_q[l]];
    pend_nxt = pend_q & ~served;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      op_q    <= OP_READ;
      pend_q  <= '0;
      bank_q  <= '0;
      row_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid_i) begin
          busy_q  <= 1'b1;
          op_q    <= req_op_i;
          pend_q  <= req_mask_i;
          wdata_q <= req_wdata_i;
          rdata_q <= '0;
          for (int l = 0; l < NUM_LANES; l++) begin
            bank_q[l] <= req_addr_i[l][BANK_W-1:0];
            row_q[l]  <= req_addr_i[l][ADDR_W-1:BANK_W];
          end
        end
      end else begin
        for (int l = 0; l < NUM_LANES; l++)
          if (served[l] && !is_wr) rdata_q[l] <= lane_rd[l];
        pend_q <= pend_nxt;
        if (pend_nxt == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign req_ready_o = !busy_q;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/sp_scratchpad_chk.sv
module sp_scratchpad_chk #(
  parameter int NUM_LANES = 16,
  parameter int DATA_W    = 32
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             req_valid_i,
  input logic                             req_ready_o,
  input logic                             done_o,
  input logic [NUM_LANES-1:0][DATA_W-1:0] rdata_o
);
  localparam int CNT_W = $clog2(NUM_LANES) + 2;
  logic [CNT_W-1:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt_q <= '0;
    else         busy_cnt_q <= req_ready_o ? '0 : busy_cnt_q + 1'b1;
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o); // R11
  AST_READY_RISE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ready_o) |-> done_o); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !req_valid_i) |=> $stable(rdata_o)); // R11
  AST_SERVICE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt_q <= CNT_W'(NUM_LANES)); // R4
endmodule

bind sp_scratchpad sp_scratchpad_chk #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sp_scratchpad.sv
`timescale 1ns/1ps
module tb_sp_scratchpad;
  localparam int NL = 16;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NW = 1 << AW;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [1:0]           req_op = 2'b00;
  logic [NL-1:0]        req_mask = '0;
  logic [NL-1:0][AW-1:0] req_addr = '0;
  logic [NL-1:0][DW-1:0] req_wdata = '0;
  logic                 done;
  logic [NL-1:0][DW-1:0] rdata;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] mem_m [NW];

  logic [NL-1:0]         t_mask;
  logic [NL-1:0][AW-1:0] t_addr;
  logic [NL-1:0][DW-1:0] t_wd;

  always #2 clk = ~clk;

  sp_scratchpad dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_mask_i(req_mask), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .done_o(done), .rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] op, input bit inject, input string tag);
    logic [DW-1:0] exp_rd [NL];
    int exp_cyc, n;
    exp_cyc = 0;
    for (int b = 0; b < 32; b++) begin
      int cnt = 0;
      for (int l = 0; l < NL; l++) begin
        if (t_mask[l] && (t_addr[l] % 32) == b) begin
          bit dup = 0;
          if (op != 2'b10)
            for (int k = 0; k < l; k++)
              if (t_mask[k] && t_addr[k] == t_addr[l]) dup = 1;
          if (!dup) cnt++;
        end
      end
      if (cnt > exp_cyc) exp_cyc = cnt;
    end
    if (exp_cyc == 0) exp_cyc = 1;
    for (int l = 0; l < NL; l++) begin
      exp_rd[l] = '0;
      if (t_mask[l]) begin
        case (op)
          2'b00: exp_rd[l] = mem_m[t_addr[l]];
          2'b01: mem_m[t_addr[l]] = t_wd[l];
          default: begin
            exp_rd[l] = mem_m[t_addr[l]];
            mem_m[t_addr[l]] = mem_m[t_addr[l]] + t_wd[l];
          end
        endcase
      end
    end

    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready idle", req_ready, 1);
    req_valid = 1'b1; req_op = op; req_mask = t_mask; req_addr = t_addr; req_wdata = t_wd;
    @(posedge clk);
    @(negedge clk);
    if (inject) begin
      req_op = 2'b01; req_mask = '1;
      for (int l = 0; l < NL; l++) begin
        req_addr[l] = AW'(1000);
        req_wdata[l] = 32'hDEAD_0000 + l;
      end
    end else req_valid = 1'b0;
    chk(req_ready == 1'b0 && done == 1'b0, "R9", "busy after accept", {req_ready, done}, 0);
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      req_valid = 1'b0;
      if (done) break;
      chk(req_ready == 1'b0, "R9", "ready low while busy", req_ready, 0);
      if (n > 40) begin
        chk(1'b0, tag, "no done", n, exp_cyc);
        break;
      end
    end
    chk(n == exp_cyc, tag, "service cycles", n, exp_cyc);
    for (int l = 0; l < NL; l++)
      chk(rdata[l] == exp_rd[l], tag, $sformatf("lane %0d rdata", l), rdata[l], exp_rd[l]);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done single pulse", done, 0);
    for (int l = 0; l < NL; l++)
      chk(rdata[l] == exp_rd[l], "R11", $sformatf("lane %0d rdata held", l), rdata[l], exp_rd[l]);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R1", "ready/done in reset", {req_ready, done}, 2'b10);
    chk(rdata == '0, "R1", "rdata in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && rdata == '0, "R1", "state after reset",
        {req_ready, done}, 2'b10);

    // fill storage: 16 consecutive words hit 16 distinct banks (R3)
    for (int r = 0; r < NW / NL; r++) begin
      t_mask = '1;
      for (int l = 0; l < NL; l++) begin
        t_addr[l] = AW'(r * NL + l);
        t_wd[l]   = (r * NL + l) * 32'h0001_0003 + 32'h55;
      end
      run_req(2'b01, 1'b0, "R3");
    end

    // distinct banks, varied rows: one cycle (R3, R8)
    for (int l = 0; l < NL; l++) t_addr[l] = AW'(((l * 7) % 32) * 32 + l * 2);
    run_req(2'b00, 1'b0, "R3");

    // all lanes same bank, distinct rows: 16 cycles (R2, R4)
    for (int l = 0; l < NL; l++) t_addr[l] = AW'(l * 32 + 5);
    run_req(2'b00, 1'b0, "R2");

    // broadcast: all lanes one word (R5)
    for (int l = 0; l < NL; l++) t_addr[l] = AW'(77);
    run_req(2'b00, 1'b0, "R5");

    // mixed: lanes 0-7 share a word, lanes 8-15 in pairs over 4 rows of same bank (R4, R5)
    for (int l = 0; l < NL; l++)
      t_addr[l] = (l < 8) ? AW'(3 + 32 * 9) : AW'(3 + 32 * ((l - 8) / 2));
    run_req(2'b00, 1'b0, "R4");

    // atomics on one word: serialized, prefix values returned (R6)
    for (int l = 0; l < NL; l++) begin t_addr[l] = AW'(200); t_wd[l] = 32'(l + 1); end
    run_req(2'b10, 1'b0, "R6");
    // atomics on distinct banks: one cycle (R6)
    for (int l = 0; l < NL; l++) begin t_addr[l] = AW'(l + 400); t_wd[l] = 32'hFFFF_FFF0 + l; end
    run_req(2'b10, 1'b0, "R6");
    // read back atomic results (R8)
    for (int l = 0; l < NL; l++) t_addr[l] = (l < 8) ? AW'(200) : AW'(l + 392);
    run_req(2'b00, 1'b0, "R8");

    // same-word writes: highest lane wins (R7), then read (R8)
    for (int l = 0; l < NL; l++) begin t_addr[l] = AW'(321); t_wd[l] = 32'hC0DE_0000 + l; end
    run_req(2'b01, 1'b0, "R7");
    run_req(2'b00, 1'b0, "R7");

    // partial mask: inactive lanes read 0 and do not write (R10)
    t_mask = 16'h5A0F;
    for (int l = 0; l < NL; l++) begin t_addr[l] = AW'(600 + l); t_wd[l] = 32'hBEEF_0000 + l; end
    run_req(2'b01, 1'b0, "R10");
    run_req(2'b10, 1'b0, "R10");
    t_mask = '1;
    run_req(2'b00, 1'b0, "R10");
    t_mask = '0;
    run_req(2'b00, 1'b0, "R4");
    t_mask = '1;

    // request presented while busy is ignored (R9)
    for (int l = 0; l < NL; l++) t_addr[l] = AW'(l * 32 + 8);
    run_req(2'b00, 1'b1, "R9");
    for (int l = 0; l < NL; l++) t_addr[l] = AW'(1000);
    run_req(2'b00, 1'b0, "R9");

    // random patterns (R4, R6, R8)
    for (int i = 0; i < 60; i++) begin
      logic [1:0] op;
      op = 2'($urandom % 3);
      t_mask = 16'($urandom);
      for (int l = 0; l < NL; l++) begin
        t_addr[l] = AW'($urandom % 96);
        t_wd[l]   = $urandom;
      end
      run_req(op, 1'b0, "R4");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule